// File: doc/BRIEF.md
# Scalable 64-bit System Counter

This block keeps a 64-bit system time value that advances on a reference tick input. Software reaches it through a small frame of 32-bit registers on a simple register bus. The frame holds a control word, a read-only status word, the count as a low and a high word, and a scale word.

With the enable bit set and scaling off, the count rises by one on every tick. With scaling on, each tick adds a fixed-point increment taken from the scale word. The increment has 8 integer bits and 24 fractional bits. The fraction builds up in a hidden accumulator, so the count can run slower or faster than the tick rate. The count holds its value while the counter is stopped. Software can load either half of the count at any time.

Top module: `sysctr_top`

## Requirements
- R1: The frame decodes five word offsets: control 0x00, status 0x04, count low word 0x08, count high word 0x0C, scale 0x10. A read (busSel=1, busWr=0) raises busRvalid in the next cycle and presents its data on busRdata. Any other offset reads as 0.
- R2: After reset, control reads 0, status reads 0x2, both count words read 0, and scale reads 0x01000000.
- R3: While control bit 0 is 0, the count does not change, however many ticks arrive.
- R4: Control bit 0 enables counting. With control bit 2 clear, each cycle with tickIn=1 raises the count by exactly 1.
- R5: With control bits 0 and 2 both set, each tick adds the scale word to {count, fraction}, where the fraction is 24 bits wide. So 0x01000000 is 1.0, 0x00100000 is 1/16 and 0x02800000 is 2.5. The count and the fraction are both kept across a disable and a re-enable.
- R6: A write to the count low word leaves the high word unchanged, and the reverse also holds. A count step carries from the low word into the high word.
- R7: Status bit 1 reads 1 exactly when control bit 0 is 0, and every other status bit reads 0. Writes to status change no register.
- R8: A write to scale takes effect only while control bit 0 is 0. A write made while it is 1 is dropped.
- R9: A write to either count word clears the hidden fraction. If a count write and a tick fall in the same cycle, the written value is kept and the tick is lost.
- R10: A count read issued in the same cycle as a tick returns the count after that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | Reference tick, one step per high cycle |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (5) | Byte offset within the frame |
| busWdata | input | 32 | Write data |
| busRvalid | output | 1 | Read data valid, one cycle after a read |
| busRdata | output | 32 | Read data, 0 when busRvalid is 0 |

## Verification
The bench uses the default parameters: a 64-bit count, a 24-bit fraction and a 32-bit scale word. Since a tick cannot reach the 64-bit wrap in any feasible run, the low-to-high carry is reached by loading 0xFFFFFFFF into the low word before a tick. The 24-bit fraction makes the 1/16, 1/2 and 2.5 increments exact, so each scaled result is an exact integer. A half-step increment shows whether a count write clears the fraction: one tick after the write leaves the count unchanged, and the second tick raises it by one.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned OFF_CTRL = 'h00;
  localparam int unsigned OFF_STAT = 'h04;
  localparam int unsigned OFF_LO   = 'h08;
  localparam int unsigned OFF_HI   = 'h0C;
  localparam int unsigned OFF_SCL  = 'h10;

  typedef struct packed {
    logic advance;  // tick accepted this cycle
    logic scaled;   // use fixed-point increment
    logic wrLo;     // load count low word
    logic wrHi;     // load count high word
  } ctrStrobe_t;
endpackage

// File: rtl/sysctr_ctrl.sv
module sysctr_ctrl
  import sysctr_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int CNT_W       = 64,
  parameter int SCALE_W     = 32,
  parameter int SCALE_RESET = 32'h0100_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickIn,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [WORD_W-1:0]  busWdata,
  input  logic [CNT_W-1:0]   countIn,
  output ctrStrobe_t         strb,
  output logic [SCALE_W-1:0] scaleOut,
  output logic               enOut,
  output logic               scaleEnOut,
  output logic               busRvalid,
  output logic [WORD_W-1:0]  busRdata
);
  localparam int HI_W = CNT_W - WORD_W;

  logic               enQ, scaleEnQ, rdPendQ;
  logic [SCALE_W-1:0] scaleQ;
  logic [ADDR_W-1:0]  rdAddrQ;
  logic               wrHit, rdHit;
  logic [WORD_W-1:0]  rdMux;

  assign wrHit = busSel & busWr;
  assign rdHit = busSel & ~busWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ      <= 1'b0;
      scaleEnQ <= 1'b0;
      scaleQ   <= SCALE_W'(SCALE_RESET);
      rdPendQ  <= 1'b0;
      rdAddrQ  <= '0;
    end else begin
      rdPendQ <= rdHit;
      if (rdHit) rdAddrQ <= busAddr;
      if (wrHit && busAddr == ADDR_W'(OFF_CTRL)) begin
        enQ      <= busWdata[0];
        scaleEnQ <= busWdata[2];
      end
      if (wrHit && busAddr == ADDR_W'(OFF_SCL) && !enQ)
        scaleQ <= busWdata[SCALE_W-1:0];
    end
  end

  always_comb begin
    strb.advance = enQ & tickIn;
    strb.scaled  = scaleEnQ;
    strb.wrLo    = wrHit && (busAddr == ADDR_W'(OFF_LO));
    strb.wrHi    = wrHit && (busAddr == ADDR_W'(OFF_HI));
  end

  always_comb begin
    rdMux = '0;
    case (rdAddrQ)
      ADDR_W'(OFF_CTRL): rdMux = {{(WORD_W-3){1'b0}}, scaleEnQ, 1'b0, enQ};
      ADDR_W'(OFF_STAT): rdMux = {{(WORD_W-2){1'b0}}, ~enQ, 1'b0};
      ADDR_W'(OFF_LO):   rdMux = countIn[WORD_W-1:0];
      ADDR_W'(OFF_HI):   rdMux = WORD_W'(countIn[CNT_W-1:CNT_W-HI_W]);
      ADDR_W'(OFF_SCL):  rdMux = WORD_W'(scaleQ);
      default:           rdMux = '0;
    endcase
  end

  assign busRvalid  = rdPendQ;
  assign busRdata   = rdPendQ ? rdMux : '0;
  assign scaleOut   = scaleQ;
  assign enOut      = enQ;
  assign scaleEnOut = scaleEnQ;
endmodule

// File: rtl/sysctr_datapath.sv
module sysctr_datapath
  import sysctr_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int FRAC_W  = 24,
  parameter int SCALE_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrStrobe_t         strb,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [SCALE_W-1:0] scale,
  output logic [CNT_W-1:0]   countOut
);
  localparam int ACC_W = CNT_W + FRAC_W;
  localparam int HI_W  = CNT_W - WORD_W;

  logic [CNT_W-1:0]  countQ;
  logic [FRAC_W-1:0] fracQ;
  logic [ACC_W-1:0]  accSum;

  assign accSum = {countQ, fracQ} + ACC_W'(scale);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      fracQ  <= '0;
    end else if (strb.wrLo) begin
      countQ[WORD_W-1:0] <= wdata;
      fracQ              <= '0;
    end else if (strb.wrHi) begin
      countQ[CNT_W-1:WORD_W] <= wdata[HI_W-1:0];
      fracQ                  <= '0;
    end else if (strb.advance) begin
      if (strb.scaled) {countQ, fracQ} <= accSum;
      else             countQ <= countQ + CNT_W'(1);
    end
  end

  assign countOut = countQ;
endmodule

// File: rtl/sysctr_top.sv
module sysctr_top
  import sysctr_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int CNT_W       = 64,
  parameter int FRAC_W      = 24,
  parameter int SCALE_W     = 32,
  parameter int SCALE_RESET = 32'h0100_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic              busRvalid,
  output logic [31:0]       busRdata
);
  ctrStrobe_t         strb;
  logic [CNT_W-1:0]   countVal;
  logic [SCALE_W-1:0] scaleVal;
  logic               enVal, scaleEnVal;

  sysctr_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SCALE_W(SCALE_W), .SCALE_RESET(SCALE_RESET)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .countIn(countVal), .strb(strb),
    .scaleOut(scaleVal), .enOut(enVal), .scaleEnOut(scaleEnVal),
    .busRvalid(busRvalid), .busRdata(busRdata)
  );

  sysctr_datapath #(
    .CNT_W(CNT_W), .FRAC_W(FRAC_W), .SCALE_W(SCALE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata),
    .scale(scaleVal), .countOut(countVal)
  );
endmodule

// File: rtl/sysctr_checker.sv
module sysctr_checker
  import sysctr_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int CNT_W   = 64,
  parameter int SCALE_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               tickIn,
  input logic               busSel,
  input logic               busWr,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busRvalid,
  input logic [31:0]        busRdata,
  input logic [CNT_W-1:0]   countVal,
  input logic [SCALE_W-1:0] scaleVal,
  input logic               enVal,
  input logic               scaleEnVal,
  input ctrStrobe_t         strb
);
  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rstN) (busSel && !busWr) |=> busRvalid); // R1
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rstN) (!enVal && !strb.wrLo && !strb.wrHi) |=> $stable(countVal)); // R3
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rstN) (enVal && !scaleEnVal && tickIn && !strb.wrLo && !strb.wrHi) |=> (countVal == $past(countVal) + CNT_W'(1))); // R4
  AST_HI_KEEP: assert property (@(posedge clk) disable iff (!rstN) strb.wrLo |=> (countVal[CNT_W-1:WORD_W] == $past(countVal[CNT_W-1:WORD_W]))); // R6
  AST_STATUS_HALT: assert property (@(posedge clk) disable iff (!rstN) (busSel && !busWr && busAddr == ADDR_W'(OFF_STAT)) |=> (busRdata[1] == !enVal)); // R7
  AST_SCALE_LOCK: assert property (@(posedge clk) disable iff (!rstN) enVal |=> $stable(scaleVal)); // R8
endmodule

bind sysctr_top sysctr_checker #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SCALE_W(SCALE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .tickIn(tickIn), .busSel(busSel), .busWr(busWr),
  .busAddr(busAddr), .busRvalid(busRvalid), .busRdata(busRdata),
  .countVal(countVal), .scaleVal(scaleVal), .enVal(enVal),
  .scaleEnVal(scaleEnVal), .strb(strb)
);

// File: tb/sysctr_top_tb.sv
module sysctr_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busRvalid;
  logic [31:0] busRdata;
  int          nChecks = 0;
  int          nErrors = 0;
  bit          finished = 1'b0;

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_LO = 5'h08,
                         A_HI = 5'h0C, A_SCL = 5'h10;

  sysctr_top u_dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRvalid(busRvalid), .busRdata(busRdata)
  );

  always #10 clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
    d = busRvalid ? busRdata : 32'hDEAD_BEEF;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tickIn = 1'b1;
      @(negedge clk);
    end
    tickIn = 1'b0;
  endtask

  task automatic expectReg(input logic [4:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    check(v, exp, req);
  endtask

  task automatic t_reset();
    expectReg(A_CTRL, 32'h0, "R2 ctrl");
    expectReg(A_STAT, 32'h2, "R2 status");
    expectReg(A_SCL, 32'h0100_0000, "R2 scale");
    expectReg(A_LO, 32'h0, "R2 lo");
    expectReg(A_HI, 32'h0, "R2 hi");
    expectReg(5'h14, 32'h0, "R1 unmapped");
  endtask

  task automatic t_halted();
    ticks(100);
    expectReg(A_LO, 32'h0, "R3 halted lo");
    expectReg(A_HI, 32'h0, "R3 halted hi");
  endtask

  task automatic t_unit();
    wr(A_CTRL, 32'h1);
    expectReg(A_STAT, 32'h0, "R7 running status");
    ticks(100);
    expectReg(A_LO, 32'd100, "R4 unit count");
    expectReg(A_HI, 32'h0, "R4 unit hi");
  endtask

  task automatic t_scaled();
    wr(A_CTRL, 32'h0);
    wr(A_SCL, 32'h0010_0000);
    expectReg(A_SCL, 32'h0010_0000, "R8 scale write halted");
    wr(A_CTRL, 32'h5);
    expectReg(A_CTRL, 32'h5, "R1 ctrl readback");
    ticks(160);
    expectReg(A_LO, 32'd110, "R5 sixteenth speed");
  endtask

  task automatic t_scaleLock();
    wr(A_SCL, 32'h0200_0000);
    expectReg(A_SCL, 32'h0010_0000, "R8 scale locked");
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_status();
    wr(A_STAT, 32'hFFFF_FFFF);
    expectReg(A_STAT, 32'h2, "R7 status write ignored");
    expectReg(A_CTRL, 32'h0, "R7 ctrl untouched");
    expectReg(A_LO, 32'd110, "R7 count untouched");
  endtask

  task automatic t_halves();
    wr(A_LO, 32'h1234_5678);
    wr(A_HI, 32'h9ABC_DEF0);
    expectReg(A_LO, 32'h1234_5678, "R6 lo kept by hi write");
    wr(A_LO, 32'h1111_1111);
    expectReg(A_HI, 32'h9ABC_DEF0, "R6 hi kept by lo write");
    expectReg(A_LO, 32'h1111_1111, "R6 lo written");
  endtask

  task automatic t_carry();
    wr(A_HI, 32'h0);
    wr(A_LO, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h1);
    ticks(1);
    wr(A_CTRL, 32'h0);
    expectReg(A_LO, 32'h0, "R6 carry lo");
    expectReg(A_HI, 32'h1, "R6 carry hi");
  endtask

  task automatic t_frac();
    wr(A_SCL, 32'h0080_0000);
    wr(A_LO, 32'h0);
    wr(A_HI, 32'h0);
    wr(A_CTRL, 32'h5);
    ticks(1);
    expectReg(A_LO, 32'h0, "R5 half step");
    wr(A_LO, 32'h0);
    ticks(1);
    expectReg(A_LO, 32'h0, "R9 fraction cleared");
    ticks(1);
    expectReg(A_LO, 32'h1, "R9 fraction rebuilt");
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h5);
    ticks(2);
    expectReg(A_LO, 32'h2, "R5 kept over re-enable");
  endtask

  task automatic t_writeWins();
    wr(A_CTRL, 32'h1);
    tickIn = 1'b1;
    wr(A_LO, 32'd50);
    tickIn = 1'b0;
    expectReg(A_LO, 32'd50, "R9 write beats tick");
  endtask

  task automatic t_readTick();
    logic [31:0] v;
    tickIn = 1'b1;
    rd(A_LO, v);
    tickIn = 1'b0;
    check(v, 32'd51, "R10 read in tick cycle");
  endtask

  task automatic t_fast();
    wr(A_CTRL, 32'h0);
    wr(A_SCL, 32'h0280_0000);
    wr(A_LO, 32'h0);
    wr(A_CTRL, 32'h5);
    ticks(4);
    expectReg(A_LO, 32'd10, "R5 two and a half speed");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_halted();
    t_unit();
    t_scaled();
    t_scaleLock();
    t_status();
    t_halves();
    t_carry();
    t_frac();
    t_writeWins();
    t_readTick();
    t_fast();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end
endmodule